// File: doc/BRIEF.md
# Square-Channel Volume Envelope Generator

This block supplies the 4-bit loudness value for one square-wave sound voice. A single 4-bit setting field does two jobs. When the constant-volume flag is low, the field sets how fast a 4-bit decay level falls from full scale. When the flag is high, the field is itself the output level. The decay level is stepped by a small programmable divider. The divider advances only on envelope ticks. A tick is a one-cycle enable pulse on the system clock, supplied by an external frame sequencer.

Software starts a new note by writing the voice's final control register. The block sees this write as a one-cycle strobe. The strobe does not act at once. It only sets a sticky restart request. The next tick then performs the restart: the level goes to full scale and the divider reloads, and that tick does no normal counting. With the loop flag set, the level wraps from 0 back to full scale on the next divider expiry, which gives a repeating sawtooth. With the loop flag clear, the level stays at 0.

No data stream enters or leaves the block, so there is no valid/ready handshake. Every pin is a plain control or status signal. The output is combinational from the decay register, the setting field and the constant-volume flag.

Top module: `env_volume_gen`

## Requirements
- R1: With setting field value n, the decay level steps once every n+1 ticks after a restart. A restart tick loads the divider with n. Each later tick counts it down by one, and the tick that finds it at 0 expires it and reloads it with n.
- R2: A tick that arrives while a restart request is pending sets the decay level to 15 and reloads the divider with n. That tick does not decrement the level.
- R3: In cycles without a tick, the decay level and the divider hold their values.
- R4: A divider expiry with the decay level above 0 lowers the level by exactly one.
- R5: A divider expiry with the decay level at 0 and the loop flag set reloads the level to 15.
- R6: With the loop flag clear, a decay level of 0 stays at 0 on every later tick until the next restart.
- R7: When the constant-volume flag is 1, the output equals the setting field. When the flag is 0, the output equals the decay level.
- R8: A write strobe only sets the pending request and leaves the output unchanged until a tick. A strobe in the same cycle as a tick is not served by that tick. It is served by the next tick.
- R9: After reset the decay level is 0, no restart is pending and the divider is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle envelope tick enable |
| setting_i | input | 4 | Decay rate (n) or fixed level |
| loop_i | input | 1 | Wrap from 0 to 15 on expiry |
| const_vol_i | input | 1 | 1: output the setting field directly |
| restart_wr_i | input | 1 | Strobe for a write to the note-start register |
| vol_o | output | 4 | Volume to the channel mixer |

## Verification
Decay is tested with rate n=2 and with n=0. The n=2 run separates a correct n+1 tick period from an n-tick or n+2-tick period. The n=0 run checks that a level is lost on every tick. Running the full fall to 0 twice, once with the loop flag and once without, separates the wrap to 15 from the hold at 0. A strobe with no tick, and a strobe in the same cycle as a tick, both check that the restart waits for a later tick. Switching the constant-volume flag while the setting field changes checks that the output source is chosen by that flag.

// File: rtl/env_pkg.sv
package env_pkg;
  localparam int ENV_VOL_W = 4;

  // what a clock cycle does to the divider and decay level
  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_RESTART = 2'd1,
    ACT_STEP    = 2'd2
  } env_act_e;
endpackage

// File: rtl/env_restart_flag.sv
module env_restart_flag (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  env_pkg::env_act_e act_i,
  output logic              pend_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (wr_i)
      pend_q <= 1'b1;
    else if (act_i == env_pkg::ACT_RESTART)
      pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/env_divider.sv
module env_divider #(
  parameter int W = env_pkg::ENV_VOL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  env_pkg::env_act_e act_i,
  input  logic [W-1:0]      reload_i,
  output logic [W-1:0]      cnt_o,
  output logic              expire_o
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = (act_i == env_pkg::ACT_STEP) && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else begin
      unique case (act_i)
        env_pkg::ACT_RESTART: cnt_q <= reload_i;
        env_pkg::ACT_STEP:    cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
        default:              cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/env_decay.sv
module env_decay #(
  parameter int W = env_pkg::ENV_VOL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  env_pkg::env_act_e act_i,
  input  logic              expire_i,
  input  logic              loop_i,
  output logic [W-1:0]      level_o
);
  localparam logic [W-1:0] FULL = {W{1'b1}};
  logic [W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      level_q <= '0;
    else if (act_i == env_pkg::ACT_RESTART)
      level_q <= FULL;
    else if (expire_i) begin
      if (level_q != '0)
        level_q <= level_q - 1'b1;
      else if (loop_i)
        level_q <= FULL;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/env_volume_gen.sv
module env_volume_gen #(
  parameter int VOL_W = env_pkg::ENV_VOL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [VOL_W-1:0] setting_i,
  input  logic             loop_i,
  input  logic             const_vol_i,
  input  logic             restart_wr_i,
  output logic [VOL_W-1:0] vol_o
);
  env_pkg::env_act_e act;
  logic              pend_q;
  logic              expire;
  logic [VOL_W-1:0]  div_q;
  logic [VOL_W-1:0]  decay_q;

  always_comb begin
    if (!tick_i)     act = env_pkg::ACT_IDLE;
    else if (pend_q) act = env_pkg::ACT_RESTART;
    else             act = env_pkg::ACT_STEP;
  end

  env_restart_flag u_flag (
    .clk(clk), .rst_n(rst_n), .wr_i(restart_wr_i), .act_i(act), .pend_o(pend_q)
  );

  env_divider #(.W(VOL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .act_i(act), .reload_i(setting_i),
    .cnt_o(div_q), .expire_o(expire)
  );

  env_decay #(.W(VOL_W)) u_decay (
    .clk(clk), .rst_n(rst_n), .act_i(act), .expire_i(expire),
    .loop_i(loop_i), .level_o(decay_q)
  );

  assign vol_o = const_vol_i ? setting_i : decay_q;
endmodule

// File: rtl/env_volume_chk.sv
module env_volume_chk #(
  parameter int VOL_W = env_pkg::ENV_VOL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic [VOL_W-1:0] setting_i,
  input logic             loop_i,
  input logic             const_vol_i,
  input logic             restart_wr_i,
  input logic [VOL_W-1:0] vol_o,
  input logic             pend_q,
  input logic [VOL_W-1:0] div_q,
  input logic [VOL_W-1:0] decay_q
);
  localparam logic [VOL_W-1:0] FULL = {VOL_W{1'b1}};

  AST_DIV_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !pend_q && div_q != '0 |=> div_q == $past(div_q) - 1'b1); // R1
  AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && pend_q |=> decay_q == FULL && div_q == $past(setting_i)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(decay_q) && $stable(div_q)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !pend_q && div_q == '0 && decay_q != '0 |=> decay_q == $past(decay_q) - 1'b1); // R4
  AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !pend_q && div_q == '0 && decay_q == '0 && loop_i |=> decay_q == FULL); // R5
  AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !pend_q && decay_q == '0 && !loop_i |=> decay_q == '0); // R6
  AST_CONST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    const_vol_i |-> vol_o == setting_i); // R7
  AST_WRITE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    restart_wr_i |=> pend_q); // R8
endmodule

bind env_volume_gen env_volume_chk #(.VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .setting_i(setting_i),
  .loop_i(loop_i), .const_vol_i(const_vol_i), .restart_wr_i(restart_wr_i),
  .vol_o(vol_o), .pend_q(pend_q), .div_q(div_q), .decay_q(decay_q)
);

// File: tb/tb_env_volume_gen.sv
module tb_env_volume_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] setting_i = '0;
  logic       loop_i = 1'b0;
  logic       const_vol_i = 1'b0;
  logic       restart_wr_i = 1'b0;
  logic [3:0] vol_o;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  env_volume_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .setting_i(setting_i),
    .loop_i(loop_i), .const_vol_i(const_vol_i), .restart_wr_i(restart_wr_i),
    .vol_o(vol_o)
  );

  task automatic check(string req, logic [3:0] exp);
    n_chk++;
    if (vol_o !== exp) begin
      n_err++;
      $display("FAIL %s: vol actual=%0d expected=%0d", req, vol_o, exp);
    end
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic write_strobe();
    @(negedge clk) restart_wr_i = 1'b1;
    @(negedge clk) restart_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset level", 4'd0);
  endtask

  task automatic t_decay_rate();
    setting_i = 4'd2;
    write_strobe();
    check("R8 write alone no effect", 4'd0);
    ticks(1);
    check("R2 restart to 15", 4'd15);
    repeat (4) @(negedge clk);
    check("R3 idle holds", 4'd15);
    ticks(2);
    check("R1 no step before n+1 ticks", 4'd15);
    ticks(1);
    check("R4 step after n+1 ticks", 4'd14);
    ticks(3);
    check("R1 second period", 4'd13);
  endtask

  task automatic t_loop();
    setting_i = 4'd0;
    loop_i = 1'b1;
    write_strobe();
    ticks(1);
    check("R2 restart n=0", 4'd15);
    ticks(15);
    check("R4 fall to 0", 4'd0);
    ticks(1);
    check("R5 loop wraps to 15", 4'd15);
  endtask

  task automatic t_floor();
    loop_i = 1'b0;
    ticks(15);
    check("R4 fall to 0 no loop", 4'd0);
    ticks(3);
    check("R6 held at 0", 4'd0);
  endtask

  task automatic t_const();
    const_vol_i = 1'b1;
    setting_i = 4'd9;
    @(negedge clk);
    check("R7 fixed level 9", 4'd9);
    setting_i = 4'd3;
    @(negedge clk);
    check("R7 fixed level 3", 4'd3);
    const_vol_i = 1'b0;
    @(negedge clk);
    check("R7 back to decay level", 4'd0);
  endtask

  task automatic t_coincident();
    setting_i = 4'd0;
    @(negedge clk) begin restart_wr_i = 1'b1; tick_i = 1'b1; end
    @(negedge clk) begin restart_wr_i = 1'b0; tick_i = 1'b0; end
    check("R8 same-cycle tick not served", 4'd0);
    ticks(1);
    check("R8 next tick restarts", 4'd15);
  endtask

  initial begin
    t_reset();
    t_decay_rate();
    t_loop();
    t_floor();
    t_const();
    t_coincident();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule